// File: doc/BRIEF.md
# UART Host Register Interface

This block is the host-facing register file of a 16550-style serial channel. A host reaches it through a 3-bit offset with separate read and write strobes. The block holds these registers: interrupt enable, line control, modem control, scratch and a 16-bit baud divisor. It passes receive-buffer reads and transmit-buffer writes on to the serial datapath as single-cycle pulses. It also contains the programmable baud generator, which turns the divisor into a one-cycle tick at sixteen times the bit rate.

The top bit of the line control register is the bank bit. When it is set, the divisor's low and high bytes replace the data and interrupt-enable registers at offsets 0 and 1. Offset 2 is split by direction. A read returns the interrupt identification code, which comes in from a stub port. A write emits a pulse that loads the FIFO control logic outside this block. The upper offsets do not depend on the bank bit. Read data is combinational while the read strobe is high and is zero at all other times.

Top module: `uart_host_regs`

## Requirements
- R1: After reset, line control, modem control, scratch, interrupt enable and the divisor all read as 0. No baud tick, receive pop, transmit push or FIFO-control write is produced.
- R2: With line control bit 7 at 0, a read of offset 0 returns `rx_byte` and raises `rx_pop` in that cycle. A write to offset 0 raises `tx_push` in that cycle with `tx_byte` equal to `wdata`.
- R3: With bit 7 at 0, offset 1 reads and writes the interrupt enable register. Only `wdata[3:0]` is stored, reads return 0 in bits 7:4, and the stored value drives `irq_enable`.
- R4: With bit 7 at 1, offsets 0 and 1 read and write the divisor low and high bytes. No `rx_pop` or `tx_push` is produced, and the interrupt enable register is left unchanged.
- R5: A read of offset 2 returns `int_ident`. A write to offset 2 raises `fifo_ctl_we` for one cycle with `fifo_ctl_byte` equal to `wdata` and changes no register.
- R6: Offsets 3, 4 and 7 are read/write line control, modem control and scratch, for either value of bit 7. A read of offset 5 returns `line_stat` and a read of offset 6 returns 0. Writes to offsets 5 and 6 change nothing.
- R7: With a nonzero divisor N and no divisor write, `baud_tick` is high for exactly one cycle in every N cycles. A divisor of 1 ticks every cycle, and 65535 is a legal divisor.
- R8: A write to either divisor byte restarts the count. The first tick comes N cycles after the write cycle, where N is the new divisor.
- R9: While the divisor is 0, `baud_tick` stays low.
- R10: With `rd_en` low, `rdata` is 0. When a read and a write hit the same register in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| rx_byte | input | 8 | Received byte from the receive datapath |
| rx_pop | output | 1 | One-cycle pulse: receive buffer read |
| tx_push | output | 1 | One-cycle pulse: transmit buffer write |
| tx_byte | output | 8 | Byte for the transmit datapath |
| int_ident | input | 8 | Interrupt identification code from the priority logic |
| fifo_ctl_we | output | 1 | One-cycle pulse: FIFO control write |
| fifo_ctl_byte | output | 8 | FIFO control value |
| line_stat | input | 8 | Line status from the datapath |
| irq_enable | output | 4 | Interrupt source enables |
| line_ctl | output | 8 | Line control register |
| modem_ctl | output | 8 | Modem control register |
| baud_tick | output | 1 | 16x baud tick |

## Verification
Two things can happen in the same cycle: a divisor write and a tick that is already due from the old count. The bench makes this happen by reloading the divisor in the middle of a count and again at several phases of short divisors. It judges the result against a model that counts cycles since the last reload. The same model also covers a read and a write to the scratch register in one cycle. There the read must return the value from before the write, and the new value must appear on the following read.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DATA    = 3'd0,
    OFS_IEN     = 3'd1,
    OFS_IDENT   = 3'd2,
    OFS_LCTL    = 3'd3,
    OFS_MCTL    = 3'd4,
    OFS_LSTAT   = 3'd5,
    OFS_MSTAT   = 3'd6,
    OFS_SCRATCH = 3'd7
  } ofs_e;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_RXBUF,
    SEL_IEN,
    SEL_DIVLO,
    SEL_DIVHI,
    SEL_IDENT,
    SEL_LCTL,
    SEL_MCTL,
    SEL_LSTAT,
    SEL_MSTAT,
    SEL_SCRATCH
  } rsel_e;

  typedef struct packed {
    logic tx_load;
    logic ien;
    logic divlo;
    logic divhi;
    logic fifo;
    logic lctl;
    logic mctl;
    logic scratch;
  } wstb_t;
endpackage

// File: rtl/uart_addr_decode.sv
module uart_addr_decode
  import uart_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              bank_sel,
  output wstb_t             wstb,
  output rsel_e             rsel,
  output logic              rx_pop
);
  ofs_e ofs;
  assign ofs = ofs_e'(addr);

  always_comb begin
    wstb   = '0;
    rsel   = SEL_NONE;
    rx_pop = 1'b0;
    case (ofs)
      OFS_DATA: begin
        if (bank_sel) begin
          wstb.divlo = wr_en;
          if (rd_en) rsel = SEL_DIVLO;
        end else begin
          wstb.tx_load = wr_en;
          rx_pop       = rd_en;
          if (rd_en) rsel = SEL_RXBUF;
        end
      end
      OFS_IEN: begin
        if (bank_sel) begin
          wstb.divhi = wr_en;
          if (rd_en) rsel = SEL_DIVHI;
        end else begin
          wstb.ien = wr_en;
          if (rd_en) rsel = SEL_IEN;
        end
      end
      OFS_IDENT: begin
        wstb.fifo = wr_en;
        if (rd_en) rsel = SEL_IDENT;
      end
      OFS_LCTL: begin
        wstb.lctl = wr_en;
        if (rd_en) rsel = SEL_LCTL;
      end
      OFS_MCTL: begin
        wstb.mctl = wr_en;
        if (rd_en) rsel = SEL_MCTL;
      end
      OFS_LSTAT: begin
        if (rd_en) rsel = SEL_LSTAT;
      end
      OFS_MSTAT: begin
        if (rd_en) rsel = SEL_MSTAT;
      end
      OFS_SCRATCH: begin
        wstb.scratch = wr_en;
        if (rd_en) rsel = SEL_SCRATCH;
      end
      default: begin
        rsel = SEL_NONE;
      end
    endcase
  end

  // R2: at most one register is written per access
  p_one_wstb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wstb));

  // R2, R4: the receive pop and a divisor read never occur together
  p_pop_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> (rsel == SEL_RXBUF));
endmodule

// File: rtl/uart_reg_bank.sv
module uart_reg_bank
  import uart_reg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IEN_W  = 4,
  localparam int DIV_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wstb_t             wstb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] lctl_q,
  output logic [DATA_W-1:0] mctl_q,
  output logic [DATA_W-1:0] scratch_q,
  output logic [IEN_W-1:0]  ien_q,
  output logic [DIV_W-1:0]  div_q,
  output logic [DIV_W-1:0]  div_d
);
  logic [DATA_W-1:0] lctl_d, mctl_d, scratch_d;
  logic [IEN_W-1:0]  ien_d;

  always_comb begin
    lctl_d    = wstb.lctl    ? wdata : lctl_q;
    mctl_d    = wstb.mctl    ? wdata : mctl_q;
    scratch_d = wstb.scratch ? wdata : scratch_q;
    ien_d     = wstb.ien     ? wdata[IEN_W-1:0] : ien_q;
    div_d     = div_q;
    if (wstb.divlo) div_d[DATA_W-1:0]     = wdata;
    if (wstb.divhi) div_d[DIV_W-1:DATA_W] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lctl_q    <= '0;
      mctl_q    <= '0;
      scratch_q <= '0;
      ien_q     <= '0;
      div_q     <= '0;
    end else begin
      lctl_q    <= lctl_d;
      mctl_q    <= mctl_d;
      scratch_q <= scratch_d;
      ien_q     <= ien_d;
      div_q     <= div_d;
    end
  end

  // R4: the divisor moves only on a divisor-byte strobe
  p_div_only_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wstb.divlo || wstb.divhi) |=> $stable(div_q));

  // R5: a FIFO-control write leaves every stored register unchanged
  p_fifo_no_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wstb.fifo |=> ($stable(lctl_q) && $stable(mctl_q) && $stable(scratch_q)
                   && $stable(ien_q) && $stable(div_q)));
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_q,
  input  logic [DIV_W-1:0] div_d,
  input  logic             reload,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             div_zero;

  assign div_zero = (div_q == '0);

  always_comb begin
    if (reload)                      cnt_d = div_d;
    else if (div_zero)               cnt_d = '0;
    else if (cnt_q <= DIV_W'(1))     cnt_d = div_q;
    else                             cnt_d = cnt_q - DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = !div_zero && (cnt_q == DIV_W'(1));

  // R9: a zero divisor with no reload gives no tick next cycle
  p_zero_div_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (div_zero && !reload) |=> !tick);

  // R8: a reload to a divisor above 1 is not followed at once by a tick
  p_reload_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && (div_d > DIV_W'(1))) |=> !tick);

  // R7: with a divisor above 1, a tick is a single-cycle pulse
  p_tick_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (div_q > DIV_W'(1)) && !reload) |=> !tick);
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_reg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              rx_pop,
  output logic              tx_push,
  output logic [DATA_W-1:0] tx_byte,
  input  logic [DATA_W-1:0] int_ident,
  output logic              fifo_ctl_we,
  output logic [DATA_W-1:0] fifo_ctl_byte,
  input  logic [DATA_W-1:0] line_stat,
  output logic [IEN_W-1:0]  irq_enable,
  output logic [DATA_W-1:0] line_ctl,
  output logic [DATA_W-1:0] modem_ctl,
  output logic              baud_tick
);
  localparam int DIV_W = 2 * DATA_W;

  wstb_t             wstb;
  rsel_e             rsel;
  logic [DATA_W-1:0] scratch_q;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              reload;

  uart_addr_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .bank_sel (line_ctl[DATA_W-1]),
    .wstb     (wstb),
    .rsel     (rsel),
    .rx_pop   (rx_pop)
  );

  uart_reg_bank #(.DATA_W(DATA_W), .IEN_W(IEN_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wstb      (wstb),
    .wdata     (wdata),
    .lctl_q    (line_ctl),
    .mctl_q    (modem_ctl),
    .scratch_q (scratch_q),
    .ien_q     (irq_enable),
    .div_q     (div_q),
    .div_d     (div_d)
  );

  assign reload = wstb.divlo | wstb.divhi;

  uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_q  (div_q),
    .div_d  (div_d),
    .reload (reload),
    .tick   (baud_tick)
  );

  assign tx_push       = wstb.tx_load;
  assign tx_byte       = wdata;
  assign fifo_ctl_we   = wstb.fifo;
  assign fifo_ctl_byte = wdata;

  always_comb begin
    case (rsel)
      SEL_RXBUF:   rdata = rx_byte;
      SEL_IEN:     rdata = {{(DATA_W-IEN_W){1'b0}}, irq_enable};
      SEL_DIVLO:   rdata = div_q[DATA_W-1:0];
      SEL_DIVHI:   rdata = div_q[DIV_W-1:DATA_W];
      SEL_IDENT:   rdata = int_ident;
      SEL_LCTL:    rdata = line_ctl;
      SEL_MCTL:    rdata = modem_ctl;
      SEL_LSTAT:   rdata = line_stat;
      SEL_SCRATCH: rdata = scratch_q;
      default:     rdata = '0;
    endcase
  end

  // R4: data/enable offsets in the divisor bank leave the enables alone
  p_ien_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr <= ADDR_W'(1)) && line_ctl[DATA_W-1]) |=> $stable(irq_enable));

  // R10: no read strobe, no read data
  p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));

  // R3: unused enable bits read as zero
  p_ien_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == ADDR_W'(1)) && !line_ctl[DATA_W-1]) |-> (rdata[DATA_W-1:IEN_W] == '0));
endmodule

// File: tb/uart_host_regs_test.sv
`timescale 1ns/1ps
module uart_host_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rx_byte = '0, int_ident = '0, line_stat = '0;
  logic [7:0] rdata, tx_byte, fifo_ctl_byte, line_ctl, modem_ctl;
  logic [3:0] irq_enable;
  logic       rx_pop, tx_push, fifo_ctl_we, baud_tick;

  always #4 clk = ~clk;

  uart_host_regs uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rx_byte(rx_byte), .rx_pop(rx_pop),
    .tx_push(tx_push), .tx_byte(tx_byte), .int_ident(int_ident),
    .fifo_ctl_we(fifo_ctl_we), .fifo_ctl_byte(fifo_ctl_byte),
    .line_stat(line_stat), .irq_enable(irq_enable), .line_ctl(line_ctl),
    .modem_ctl(modem_ctl), .baud_tick(baud_tick)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  string force_tag = "";

  // behavioural model state
  int m_lcr = 0, m_mcr = 0, m_scr = 0, m_ier = 0, m_dll = 0, m_dlm = 0;
  int m_since = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    string t;
    t = (force_tag != "") ? force_tag : tag;
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic step(input int a, input bit w, input bit r, input int wd);
    int  div, exp_rd, exp_tick;
    bit  bank;
    string rtag;
    @(negedge clk);
    addr = 3'(a); wr_en = w; rd_en = r; wdata = 8'(wd);
    rx_byte = 8'($urandom); int_ident = 8'($urandom); line_stat = 8'($urandom);
    #1;
    bank = m_lcr[7];
    div  = m_dlm * 256 + m_dll;
    exp_rd = 0;
    rtag = "R10";
    if (r) begin
      case (a)
        0: begin exp_rd = bank ? m_dll : int'(rx_byte); rtag = bank ? "R4" : "R2"; end
        1: begin exp_rd = bank ? m_dlm : m_ier; rtag = bank ? "R4" : "R3"; end
        2: begin exp_rd = int'(int_ident); rtag = "R5"; end
        3: begin exp_rd = m_lcr; rtag = "R6"; end
        4: begin exp_rd = m_mcr; rtag = "R6"; end
        5: begin exp_rd = int'(line_stat); rtag = "R6"; end
        6: begin exp_rd = 0; rtag = "R6"; end
        default: begin exp_rd = m_scr; rtag = "R6"; end
      endcase
    end
    chk(rtag, "rdata", int'(rdata), exp_rd);
    chk(bank ? "R4" : "R2", "rx_pop", int'(rx_pop), int'(r && a == 0 && !bank));
    chk(bank ? "R4" : "R2", "tx_push", int'(tx_push), int'(w && a == 0 && !bank));
    if (tx_push) chk("R2", "tx_byte", int'(tx_byte), wd);
    chk("R5", "fifo_ctl_we", int'(fifo_ctl_we), int'(w && a == 2));
    if (fifo_ctl_we) chk("R5", "fifo_ctl_byte", int'(fifo_ctl_byte), wd);
    chk("R3", "irq_enable", int'(irq_enable), m_ier);
    chk("R6", "line_ctl", int'(line_ctl), m_lcr);
    chk("R6", "modem_ctl", int'(modem_ctl), m_mcr);
    exp_tick = (div != 0 && (m_since % div) == 0) ? 1 : 0;
    chk(div == 0 ? "R9" : "R7", "baud_tick", int'(baud_tick), exp_tick);
    @(posedge clk);
    m_since++;
    if (w) begin
      case (a)
        0: if (bank) begin m_dll = wd; m_since = 1; end
        1: if (bank) begin m_dlm = wd; m_since = 1; end else m_ier = wd & 15;
        3: m_lcr = wd;
        4: m_mcr = wd;
        7: m_scr = wd;
        default: ;
      endcase
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    force_tag = "R1";
    step(7, 0, 1, 0);
    step(3, 0, 1, 0);
    step(4, 0, 1, 0);
    step(1, 0, 1, 0);
    idle(4);
    force_tag = "";
    // R6: line control, modem control
    step(3, 1, 0, 8'h1B); step(3, 0, 1, 0);
    step(4, 1, 0, 8'h13); step(4, 0, 1, 0);
    // R3: interrupt enable keeps four bits
    step(1, 1, 0, 8'hFF); step(1, 0, 1, 0);
    step(1, 1, 0, 8'hA6); step(1, 0, 1, 0);
    // R2: transmit push and receive pop
    step(0, 1, 0, 8'h5A); step(0, 0, 1, 0); step(0, 1, 1, 8'hC3);
    // R6, R10: scratch, same-cycle read and write
    step(7, 1, 0, 8'hA5); step(7, 1, 1, 8'h3C); step(7, 0, 1, 0);
    // R6: status offsets ignore writes
    step(5, 1, 0, 8'hFF); step(6, 1, 0, 8'hFF);
    step(5, 0, 1, 0); step(6, 0, 1, 0); step(7, 0, 1, 0);
    step(3, 0, 1, 0); step(4, 0, 1, 0);
    // R5: identification read, FIFO control write
    step(2, 0, 1, 0); step(2, 1, 0, 8'hC7); step(2, 1, 1, 8'h01);
    // R4: divisor bank
    step(3, 1, 0, 8'h9B);
    step(0, 1, 0, 8'h03); step(1, 1, 0, 8'h00);
    step(0, 0, 1, 0); step(1, 0, 1, 0); step(3, 0, 1, 0); step(7, 0, 1, 0);
    // R7: period 3
    idle(20);
    // R8: reload in mid-count and on tick phases
    step(0, 1, 0, 8'h05); idle(2); step(0, 1, 0, 8'h05); idle(15);
    step(1, 1, 0, 8'h00); idle(4); step(0, 1, 0, 8'h02); idle(1);
    step(0, 1, 0, 8'h02); idle(7);
    // R7: divisor 1 ticks every cycle
    step(0, 1, 0, 8'h01); idle(6);
    // R9: divisor 0 is silent
    step(0, 1, 0, 8'h00); idle(12);
    // R7: 256 and 65535
    step(1, 1, 0, 8'h01); idle(600);
    step(0, 1, 0, 8'hFF); step(1, 1, 0, 8'hFF); idle(60);
    step(0, 0, 1, 0); step(1, 0, 1, 0);
    // R4: enables survived the divisor bank; back to data bank
    step(3, 1, 0, 8'h03);
    step(1, 0, 1, 0); step(0, 0, 1, 0); step(0, 1, 0, 8'h77);
    idle(3);
    done = 1;
    summary();
    $finish;
  end
endmodule